// File: doc/BRIEF.md
# SPI Master with 16-bit Register Port

This block is a single-master SPI controller that software drives through eight 16-bit register slots. Software first sets the bit rate, the active serial clock edge and the interrupt style. It then loads a transmit word and writes a control word. That control word starts either a write (data shifted out on `mosi`) or a read (data sampled from `miso`). Writes and reads are separate operations, each with its own completion flag and its own interrupt request.

The shift engine moves one bit per serial clock period, most significant bit first, for word lengths from 4 to 32 bits. Transmit data is left-aligned in the 32-bit value formed by the high and low transmit halves. Received data is right-aligned in the 32-bit value formed by the high and low receive halves. A read always clocks at least 16 bits. Two active-low select lines are available. Each line goes low for the duration of a transfer that names it, and software can also force a line low until it is released.

Register slots, addressed by `reg_word` (the byte offset divided by two):

| Slot | Byte offset | Contents |
|---|---|---|
| 0 | 0x00 | bit0 clock enable, bits 3:1 rate code N, bit4 write interrupt enable, bit5 read interrupt enable |
| 1 | 0x02 | bit0 active edge (1 rising, 0 falling), bit5 interrupt polarity (1 active high), bit10 interrupt style (1 one-cycle pulse, 0 level) |
| 2 | 0x04 | control: bit0 read, bit1 write, bits 6:2 length−1, bit7 select line, bit10 select-force command |
| 3 | 0x06 | status: bit0 read done, bit1 write done |
| 4/5 | 0x08/0x0A | transmit low / high half |
| 6/7 | 0x0C/0x0E | receive low / high half |

Top module: `spi_reg_master`

## Requirements
- R1: After reset, both select lines are high, `sclk` is high, `mosi` is 0, both interrupt outputs are 1, and setup slots 0 and 1, the status slot and the receive slots all read 0.
- R2: Slot 0 reads back bits 5:0, slot 1 reads back bits 0, 5 and 10, and the transmit slots read back all 16 bits. The control slot reads back bits 10:2 of the last accepted control write, and bits 1:0 always read 0.
- R3: A control write with bit1 set and bit10 clear starts a write of L bits. L is field 6:2 plus 1, raised to 4 when smaller. The bits are taken from bit 31 of {slot5,slot4} downward and put on `mosi` one per serial period. The select line chosen by control bit7 is low for the whole transfer. Bit1 wins when bits 1 and 0 are both set.
- R4: A control write with bit0 set (bit1 and bit10 clear) starts a read of max(L,16) bits. The bits are shifted into {slot7,slot6} from the LSB end, so that the last bit sampled lands in bit 0, and the word is cleared at the start.
- R5: The done flag (status bit1 for a write, bit0 for a read) becomes set exactly bits × 2^(2N+2) clock cycles after the clock edge that accepts the control write, where N is slot0 bits 3:1. During this time the serial clock shows exactly `bits` active edges.
- R6: While slot0 bit0 is 0, an active transfer holds its place: `sclk` shows no edges and the done flag stays clear. The transfer resumes when the bit is set again.
- R7: With slot1 bit0 = 1 the serial clock idles low, and `mosi` is sampled on rising edges. With slot1 bit0 = 0 it idles high, and `mosi` is sampled on falling edges. Outside a transfer `sclk` stays at its idle level.
- R8: Starting a write clears the write flag, and starting a read clears the read flag. A status write clears each flag whose data bit is 0 and leaves the other flags unchanged.
- R9: The write (read) interrupt is enabled by slot0 bit4 (bit5). An enabled interrupt is active while its flag is set in level style, or for the single cycle in which the flag sets in pulse style. It drives 1 when active and the polarity bit is 1, otherwise 0 when active. A line that is not active drives the opposite value.
- R10: A control write with bit10 set starts no transfer. It forces the select line named by bit7 low when bit0 is 1 and releases it when bit0 is 0, so 0x05FD forces line 1 and 0x05FC releases it.
- R11: Control writes that arrive during a transfer are ignored. They cause no change to the transfer, the select lines, the flags or the control readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the serial clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_word | input | 3 | Register slot (byte offset / 2) |
| reg_wr | input | 1 | Write strobe for the addressed slot |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed slot (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low select lines |
| irq_wr | output | 1 | Write-complete interrupt request |
| irq_rd | output | 1 | Read-complete interrupt request |

## Verification
Suppose the bit counter or the rate counter held a wrong value. The done flag would then rise one or more cycles earlier or later than the exact count, and the number of serial edges would differ from the word length. Both effects show up on the transfer where the fault occurs. A wrong shift register or a wrong sample point would corrupt the captured `mosi` word or the receive halves as soon as that transfer completes. A select or busy state that does not clear would show on `cs_n` and on the idle `sclk` level within the very next cycle, because the bench compares both on every clock.

// File: rtl/spi_reg_master.sv
module spi_reg_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_word,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [1:0]  cs_n,
  output logic        irq_wr,
  output logic        irq_rd
);
  localparam int CNTW  = 15;
  localparam int MINWR = 4;
  localparam int MINRD = 16;

  logic [5:0]      setup1;
  logic            s2_rise, s2_pos, s2_pulse;
  logic [10:2]     ctrl_q;
  logic [1:0]      force_q;
  logic            wflag, rflag, wpulse, rpulse;
  logic [31:0]     tx_q, rx_q, sh_q;
  logic            busy, is_wr, cur_cs, half;
  logic [CNTW-1:0] cnt, lim;
  logic [5:0]      bits_left;

  wire sel_s1   = reg_wr && reg_word == 3'd0;
  wire sel_s2   = reg_wr && reg_word == 3'd1;
  wire sel_ctrl = reg_wr && reg_word == 3'd2;
  wire sel_st   = reg_wr && reg_word == 3'd3;
  wire sel_txl  = reg_wr && reg_word == 3'd4;
  wire sel_txh  = reg_wr && reg_word == 3'd5;

  wire ctrl_ok   = sel_ctrl && !busy;
  wire force_cmd = reg_wdata[10];
  wire go_wr     = ctrl_ok && !force_cmd && reg_wdata[1];
  wire go_rd     = ctrl_ok && !force_cmd && !reg_wdata[1] && reg_wdata[0];

  wire [5:0] len_req = {1'b0, reg_wdata[6:2]} + 6'd1;
  wire [5:0] len_wr  = (len_req < 6'(MINWR)) ? 6'(MINWR) : len_req;
  wire [5:0] len_rd  = (len_req < 6'(MINRD)) ? 6'(MINRD) : len_req;

  assign lim = ~({CNTW{1'b1}} << {setup1[3:1], 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup1   <= '0;
      s2_rise  <= 1'b0;
      s2_pos   <= 1'b0;
      s2_pulse <= 1'b0;
      tx_q     <= '0;
      ctrl_q   <= '0;
      force_q  <= '0;
    end else begin
      if (sel_s1) setup1 <= reg_wdata[5:0];
      if (sel_s2) begin
        s2_rise  <= reg_wdata[0];
        s2_pos   <= reg_wdata[5];
        s2_pulse <= reg_wdata[10];
      end
      if (sel_txl) tx_q[15:0]  <= reg_wdata;
      if (sel_txh) tx_q[31:16] <= reg_wdata;
      if (ctrl_ok) begin
        ctrl_q <= reg_wdata[10:2];
        if (force_cmd) force_q[reg_wdata[7]] <= reg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      is_wr     <= 1'b0;
      cur_cs    <= 1'b0;
      half      <= 1'b0;
      cnt       <= '0;
      bits_left <= '0;
      sh_q      <= '0;
      rx_q      <= '0;
      wflag     <= 1'b0;
      rflag     <= 1'b0;
      wpulse    <= 1'b0;
      rpulse    <= 1'b0;
    end else begin
      wpulse <= 1'b0;
      rpulse <= 1'b0;
      if (sel_st) begin
        wflag <= wflag & reg_wdata[1];
        rflag <= rflag & reg_wdata[0];
      end
      if (go_wr) begin
        busy      <= 1'b1;
        is_wr     <= 1'b1;
        cur_cs    <= reg_wdata[7];
        bits_left <= len_wr;
        sh_q      <= tx_q;
        cnt       <= '0;
        half      <= 1'b0;
        wflag     <= 1'b0;
      end else if (go_rd) begin
        busy      <= 1'b1;
        is_wr     <= 1'b0;
        cur_cs    <= reg_wdata[7];
        bits_left <= len_rd;
        rx_q      <= '0;
        cnt       <= '0;
        half      <= 1'b0;
        rflag     <= 1'b0;
      end else if (busy && setup1[0]) begin
        if (cnt != lim) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt  <= '0;
          half <= ~half;
          if (!half) begin
            if (!is_wr) rx_q <= {rx_q[30:0], miso};
          end else begin
            sh_q      <= {sh_q[30:0], 1'b0};
            bits_left <= bits_left - 6'd1;
            if (bits_left == 6'd1) begin
              busy <= 1'b0;
              if (is_wr) begin
                wflag  <= 1'b1;
                wpulse <= 1'b1;
              end else begin
                rflag  <= 1'b1;
                rpulse <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  assign sclk    = s2_rise ? half : ~half;
  assign mosi    = busy & is_wr & sh_q[31];
  assign cs_n[0] = ~(force_q[0] | (busy & ~cur_cs));
  assign cs_n[1] = ~(force_q[1] | (busy & cur_cs));

  wire w_act = setup1[4] & (s2_pulse ? wpulse : wflag);
  wire r_act = setup1[5] & (s2_pulse ? rpulse : rflag);
  assign irq_wr = s2_pos ? w_act : ~w_act;
  assign irq_rd = s2_pos ? r_act : ~r_act;

  always_comb begin
    case (reg_word)
      3'd0:    reg_rdata = {10'd0, setup1};
      3'd1:    reg_rdata = {5'd0, s2_pulse, 4'd0, s2_pos, 4'd0, s2_rise};
      3'd2:    reg_rdata = {5'd0, ctrl_q, 2'b00};
      3'd3:    reg_rdata = {14'd0, wflag, rflag};
      3'd4:    reg_rdata = tx_q[15:0];
      3'd5:    reg_rdata = tx_q[31:16];
      3'd6:    reg_rdata = rx_q[15:0];
      default: reg_rdata = rx_q[31:16];
    endcase
  end

  p_cs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n[cur_cs]);

  p_bits_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= 6'd32);

  p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (wflag || rflag));

  p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !setup1[0]) |=> ($stable(half) && $stable(bits_left)));

  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk != s2_rise));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_ctrl) |=> ($stable(cur_cs) && $stable(ctrl_q) && $stable(force_q)));
endmodule

// File: tb/tb_spi_reg_master.sv
module tb_spi_reg_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_word = 3'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        sclk, mosi, miso;
  logic [1:0]  cs_n;
  logic        irq_wr, irq_rd;

  spi_reg_master dut (
    .clk(clk), .rst_n(rst_n), .reg_word(reg_word), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq_wr(irq_wr), .irq_rd(irq_rd)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int mchecks = 0, mfails = 0;
  bit started = 1'b0, open = 1'b0, act_rise = 1'b0;
  logic [1:0]  force_m = 2'b00;
  logic [31:0] mpat = '0;
  int          mtop = 0, e0 = 0;
  int          tot_edges = 0;
  logic [31:0] shreg = '0;
  logic        prev_sclk = 1'b1;
  logic        last_irq_w, last_irq_r;

  assign miso = mpat[5'(mtop - (tot_edges - e0))];

  // slave-side monitor: counts active edges, captures mosi, checks idle level
  always @(negedge clk) begin
    if (started) begin
      if (open) begin
        if (sclk !== prev_sclk && sclk === act_rise) begin
          shreg     <= {shreg[30:0], mosi};
          tot_edges <= tot_edges + 1;
        end
      end else begin
        mchecks <= mchecks + 1;
        if (sclk !== ~act_rise) begin
          mfails <= mfails + 1;
          $display("FAIL R7 idle clock level: actual %0b expected %0b", sclk, ~act_rise);
        end
      end
    end
    prev_sclk <= sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_word = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_word = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_done(input bit is_w, input bit sel, input int inj,
                           input logic [15:0] injv, output int n);
    logic done;
    logic [1:0] expcs;
    n = 0; done = 1'b0;
    while (!done && n < 20000) begin
      @(posedge clk); n++;
      @(negedge clk);
      reg_wr = 1'b0; reg_word = 3'd3;
      #1;
      done  = is_w ? reg_rdata[1] : reg_rdata[0];
      expcs = ~(force_m | (done ? 2'b00 : (sel ? 2'b10 : 2'b01)));
      chk("R3 select lines each cycle", {30'd0, cs_n}, {30'd0, expcs});
      if (inj != 0 && n == inj) begin
        reg_word = 3'd2; reg_wdata = injv; reg_wr = 1'b1;
      end
    end
    last_irq_w = irq_wr;
    last_irq_r = irq_rd;
  endtask

  task automatic xfer(input bit is_w, input int len, input bit sel, input logic [15:0] s1v,
                      input logic [31:0] txw, input logic [31:0] pat, input int inj,
                      input string tag);
    int bits, n, nn, exp_cyc;
    logic [31:0] mask;
    logic [15:0] lo, hi, cw;
    nn      = int'((s1v >> 1) & 16'h7);
    bits    = is_w ? (len < 4 ? 4 : len) : (len < 16 ? 16 : len);
    mask    = (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
    exp_cyc = bits << (2 * nn + 2);
    wr(3'd0, s1v);
    if (is_w) begin
      wr(3'd4, txw[15:0]);
      wr(3'd5, txw[31:16]);
    end
    mpat = pat; mtop = bits - 1; e0 = tot_edges; open = 1'b1;
    cw = (sel ? 16'h0080 : 16'h0000) | 16'((len - 1) << 2) | (is_w ? 16'h2 : 16'h1);
    wr(3'd2, cw);
    wait_done(is_w, sel, inj, 16'h0081, n);
    open = 1'b0;
    chk({"R5 ", tag, " duration"}, n, exp_cyc);
    chk({"R5 ", tag, " edge count"}, tot_edges - e0, bits);
    if (is_w) chk({"R3 ", tag, " mosi word"}, shreg & mask, txw >> (32 - bits));
    else begin
      rd(3'd6, lo); rd(3'd7, hi);
      chk({"R4 ", tag, " rx word"}, {hi, lo}, pat & mask);
    end
  endtask

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    started = 1'b1;
    @(negedge clk);
    chk("R1 cs_n", {30'd0, cs_n}, 32'd3);
    chk("R1 sclk", {31'd0, sclk}, 32'd1);
    chk("R1 mosi", {31'd0, mosi}, 32'd0);
    chk("R1 irq lines", {30'd0, irq_wr, irq_rd}, 32'd3);
    rd(3'd0, v); chk("R1 setup1", v, 0);
    rd(3'd1, v); chk("R1 setup2", v, 0);
    rd(3'd3, v); chk("R1 status", v, 0);
    rd(3'd6, v); chk("R1 rx low", v, 0);

    wr(3'd0, 16'hFFFF); rd(3'd0, v); chk("R2 setup1 readback", v, 16'h003F);
    wr(3'd1, 16'hFFFF); act_rise = 1'b1;
    rd(3'd1, v); chk("R2 setup2 readback", v, 16'h0421);
    wr(3'd4, 16'h1234); rd(3'd4, v); chk("R2 tx low readback", v, 16'h1234);
    wr(3'd5, 16'hABCD); rd(3'd5, v); chk("R2 tx high readback", v, 16'hABCD);
    wr(3'd2, 16'h017C); rd(3'd2, v); chk("R2 ctrl readback", v, 16'h017C);
    wr(3'd1, 16'h0001);

    xfer(1'b1, 8,  1'b0, 16'h0001, 32'hA500_0000, 0, 0, "write 8b");
    xfer(1'b1, 32, 1'b1, 16'h0003, 32'h1234_5678, 0, 0, "write 32b N1");
    xfer(1'b1, 2,  1'b0, 16'h0001, 32'hC000_0000, 0, 0, "write min length");
    xfer(1'b1, 20, 1'b1, 16'h0001, 32'hFEDC_B000, 0, 0, "write 20b");
    xfer(1'b0, 8,  1'b1, 16'h0001, 0, 32'h0000_BEEF, 0, "read short");
    rd(3'd2, v); chk("R2 start bits read 0", v, 16'h0080 | 16'h001C);
    xfer(1'b0, 24, 1'b0, 16'h0001, 0, 32'h00AB_CDEF, 0, "read 24b");

    // R7 falling-edge mode
    wr(3'd1, 16'h0000); act_rise = 1'b0;
    @(negedge clk); chk("R7 idle high in falling mode", {31'd0, sclk}, 32'd1);
    xfer(1'b1, 12, 1'b0, 16'h0001, 32'h9AB0_0000, 0, 0, "R7 falling write");
    xfer(1'b0, 20, 1'b1, 16'h0001, 0, 32'h0005_C3E1, 0, "R7 falling read");
    wr(3'd1, 16'h0001); act_rise = 1'b1;
    @(negedge clk); chk("R7 idle low in rising mode", {31'd0, sclk}, 32'd0);

    // R6 clock gating
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0000); wr(3'd5, 16'h6C00);
    e0 = tot_edges; open = 1'b1;
    wr(3'd2, 16'h001E);
    repeat (20) @(posedge clk);
    chk("R6 no edges while gated", tot_edges - e0, 0);
    rd(3'd3, v); chk("R6 flag clear while gated", v, 0);
    chk("R6 select held while gated", {30'd0, cs_n}, 32'd2);
    wr(3'd0, 16'h0001);
    wait_done(1'b1, 1'b0, 0, 16'h0, n);
    open = 1'b0;
    chk("R6 duration after resume", n, 32);
    chk("R6 word after resume", shreg & 32'hFF, 32'h6C);

    // R8 flags
    wr(3'd3, 16'h0000);
    xfer(1'b1, 8, 1'b0, 16'h0001, 32'h3300_0000, 0, 0, "R8 write");
    xfer(1'b0, 4, 1'b0, 16'h0001, 0, 32'h0000_1234, 0, "R8 read");
    rd(3'd3, v); chk("R8 both flags set", v, 16'h3);
    e0 = tot_edges; open = 1'b1;
    wr(3'd2, 16'h001E);
    rd(3'd3, v); chk("R8 write start clears write flag only", v, 16'h1);
    wait_done(1'b1, 1'b0, 0, 16'h0, n);
    open = 1'b0;
    wr(3'd3, 16'h0002); rd(3'd3, v); chk("R8 status write clears zero bits", v, 16'h2);
    wr(3'd3, 16'h0000); rd(3'd3, v); chk("R8 status write all zero", v, 16'h0);

    // R9 interrupts
    wr(3'd1, 16'h0021);
    xfer(1'b1, 8, 1'b0, 16'h0031, 32'h5500_0000, 0, 0, "R9 level write");
    chk("R9 level write irq active high", {31'd0, last_irq_w}, 32'd1);
    chk("R9 read irq idle", {31'd0, last_irq_r}, 32'd0);
    @(negedge clk); chk("R9 level irq holds", {31'd0, irq_wr}, 32'd1);
    wr(3'd3, 16'h0000);
    @(negedge clk); chk("R9 level irq drops after clear", {31'd0, irq_wr}, 32'd0);
    wr(3'd1, 16'h0421);
    xfer(1'b0, 16, 1'b0, 16'h0031, 0, 32'h0000_F00D, 0, "R9 pulse read");
    chk("R9 pulse read irq at done", {31'd0, last_irq_r}, 32'd1);
    @(negedge clk); chk("R9 pulse lasts one cycle", {31'd0, irq_rd}, 32'd0);
    rd(3'd3, v); chk("R9 read flag still set", v, 16'h1);
    wr(3'd1, 16'h0001);
    @(negedge clk); chk("R9 active-low level irq", {31'd0, irq_rd}, 32'd0);
    wr(3'd3, 16'h0000);
    @(negedge clk); chk("R9 active-low idle", {31'd0, irq_rd}, 32'd1);
    wr(3'd0, 16'h0001);

    // R10 forced select
    wr(3'd2, 16'h05FD); force_m = 2'b10;
    @(negedge clk); chk("R10 force line 1", {30'd0, cs_n}, 32'd1);
    e0 = tot_edges;
    repeat (10) @(posedge clk);
    chk("R10 no transfer on force", tot_edges - e0, 0);
    rd(3'd3, v); chk("R10 no flag on force", v, 0);
    xfer(1'b1, 8, 1'b0, 16'h0001, 32'h8100_0000, 0, 0, "R10 write under force");
    wr(3'd2, 16'h05FC); force_m = 2'b00;
    @(negedge clk); chk("R10 release line 1", {30'd0, cs_n}, 32'd3);
    wr(3'd2, 16'h0401);
    @(negedge clk); chk("R10 force line 0", {30'd0, cs_n}, 32'd2);
    wr(3'd2, 16'h0400);
    @(negedge clk); chk("R10 release line 0", {30'd0, cs_n}, 32'd3);

    // R11 control write during a transfer
    wr(3'd3, 16'h0000);
    xfer(1'b1, 8, 1'b0, 16'h0005, 32'hE700_0000, 0, 10, "R11 write with injected ctrl");
    rd(3'd3, v); chk("R11 injected read not started", v, 16'h2);
    rd(3'd2, v); chk("R11 ctrl readback unchanged", v, 16'h001C);

    $display("%0d/%0d checks passed", (checks + mchecks) - (fails + mfails), checks + mchecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", (checks + mchecks) - (fails + mfails + 1), checks + mchecks + 1);
    $finish;
  end
endmodule